// File: doc/BRIEF.md
# Polarity-Programmable GPIO Bank with Alternate Pin Functions

This block is a bank of general-purpose I/O bits controlled through a small synchronous host register port. Each bit has its own configuration register. Three fields in that register select the bit's direction, whether its level is inverted, and whether an alternate function takes over the pin. A shared data register holds the output values. A bit set as an output drives its stored value to the pad, either unchanged or inverted. A bit set as an input presents its synchronised pad level to the host, either unchanged or inverted. The data read-back therefore changes meaning with direction. An output bit returns what the host stored, and an input bit returns what the pad shows.

Two bit positions can carry alternate functions. A global options register holds an infrared-select flag. When that flag is clear, the first of the two pins carries a watchdog signal and the second drives a power LED. When that flag is set, the two pins become an infrared receive and transmit pair. The receive pin is then forced to behave as an input whatever its direction field holds.

Top module: `pgpio_bank`

## Requirements
- R1: After a synchronous active-low reset, every bit is an input with no inversion and no alternate function: pin_oe is all zeros, each configuration register reads 3'b001, the data register holds zero, and the options register reads 0.
- R2: For a bit acting as an input, the data read returns the synchronised pad level, inverted when the bit's invert field (config bit 1) is 1.
- R3: A host write to the data register leaves unchanged every data bit whose pin currently acts as an input; this becomes visible when the bit is later made an output.
- R4: For a plain bit with direction field (config bit 0) equal to 0, pin_oe is 1 and pin_o equals the stored data bit XOR the invert field, from the cycle after the write.
- R5: For a bit acting as an output, the data read returns the stored data register bit, not the pad level.
- R6: With alternate enable (config bit 2) set on pin WDT_PIN and the infrared-select flag (options bit 0) clear, pin_oe is 1 and pin_o follows wdt_i without inversion, whatever the direction field holds.
- R7: With alternate enable set on pin LED_PIN and infrared-select clear, pin_oe is 1 and pin_o follows led_i without inversion.
- R8: With alternate enable set on both pins and infrared-select set, pin LED_PIN drives ir_tx_i, and pin WDT_PIN has pin_oe 0 even when its direction field is 0, with its synchronised pad level on ir_rx_o; otherwise ir_rx_o is 0.
- R9: Pad inputs pass through two flip-flops. A data read captures the synchronised level at the clock edge that samples host_rd and presents it on host_rdata after that edge, so a pad change shows on the third read strobe held from the cycle of the change, and on ir_rx_o two edges after the change.
- R10: Configuration register n (address n, for n below NBITS) stores bits 2:0 of a write as {alternate, invert, direction} and reads them back in bits 2:0 with zeros above. The data register sits at address NBITS and the options register at NBITS+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_wr | input | 1 | Write strobe |
| host_rd | input | 1 | Read strobe; host_rdata updates after the edge that samples it |
| host_addr | input | ADDR_W | Register address |
| host_wdata | input | NBITS | Write data |
| host_rdata | output | NBITS | Registered read data |
| pin_i | input | NBITS | Pad input levels |
| pin_o | output | NBITS | Pad output levels |
| pin_oe | output | NBITS | Pad output enables |
| wdt_i | input | 1 | Watchdog signal for pin WDT_PIN |
| led_i | input | 1 | Power-LED drive for pin LED_PIN |
| ir_tx_i | input | 1 | Infrared transmit data for pin LED_PIN |
| ir_rx_o | output | 1 | Infrared receive data taken from pin WDT_PIN |

## Verification
Register writes take effect on the edge that samples host_wr. Pad outputs are combinational from the registers, so the bench checks them at the falling edge right after a write. A read result is due one edge after the strobe. A pad change reaches a read only at the third strobe held from the cycle of the change, and reaches ir_rx_o two edges after it, so the bench waits at least three cycles before reading a pad level. It also checks the old-old-new read sequence and the receive-path latency cycle by cycle. Every sample is taken at a falling edge, so none races the rising edge that updates the registers.

// File: rtl/pgpio_pkg.sv
// Shared types for the GPIO bank.
// Assumes the configuration layout {alternate, invert, direction-in} in bits 2:0.
package pgpio_pkg;

    localparam int CFG_W = 3;

    typedef struct packed {
        logic alt;     // bit 2: alternate function enable
        logic inv;     // bit 1: polarity invert
        logic dir_in;  // bit 0: 1 = input
    } bit_cfg_t;

    typedef enum logic [1:0] {
        ROLE_PLAIN,
        ROLE_WDT_IRRX,
        ROLE_LED_IRTX
    } pin_role_t;

    localparam bit_cfg_t CFG_RESET = '{alt: 1'b0, inv: 1'b0, dir_in: 1'b1};

endpackage

// File: rtl/pgpio_sync.sv
// Two-flop synchroniser for the pad inputs.
// Assumes pad levels are asynchronous to clk. The flops carry no reset
// because the pad value flushes through them within two cycles.
module pgpio_sync #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    // Shift the pad level through two stages.
    always_ff @(posedge clk) begin
        meta_q <= d_i;
        sync_q <= meta_q;
    end

    assign q_o = sync_q;
endmodule

// File: rtl/pgpio_pin.sv
// Per-bit pad logic: direction, polarity, read view and alternate-function mux.
// ROLE picks the variant. A plain bit has no alternate. The watchdog/IR-receive
// bit and the LED/IR-transmit bit depend on the global IR-select flag.
// Alternate outputs are driven without inversion.
module pgpio_pin
    import pgpio_pkg::*;
#(
    parameter pin_role_t ROLE = ROLE_PLAIN
) (
    input  bit_cfg_t cfg_i,
    input  logic     data_i,
    input  logic     ir_sel_i,
    input  logic     pad_sync_i,
    input  logic     wdt_i,
    input  logic     led_i,
    input  logic     ir_tx_i,
    output logic     pin_o,
    output logic     pin_oe,
    output logic     is_input_o,
    output logic     rd_bit_o,
    output logic     ir_rx_o
);
    logic plain_in;
    logic plain_out;
    logic plain_rd;

    // Behaviour of the bit when no alternate function owns it.
    always_comb begin
        plain_in  = cfg_i.dir_in;
        plain_out = plain_in ? 1'b0 : (data_i ^ cfg_i.inv);
        plain_rd  = plain_in ? (pad_sync_i ^ cfg_i.inv) : data_i;
    end

    generate
        if (ROLE == ROLE_WDT_IRRX) begin : g_wdt
            logic unused_wdt;
            assign unused_wdt = led_i ^ ir_tx_i;

            // Watchdog output or forced IR receive when the alternate is on.
            always_comb begin
                if (cfg_i.alt && !ir_sel_i) begin
                    is_input_o = 1'b0;
                    pin_oe     = 1'b1;
                    pin_o      = wdt_i;
                    rd_bit_o   = data_i;
                    ir_rx_o    = 1'b0;
                end else if (cfg_i.alt) begin
                    is_input_o = 1'b1;
                    pin_oe     = 1'b0;
                    pin_o      = 1'b0;
                    rd_bit_o   = pad_sync_i ^ cfg_i.inv;
                    ir_rx_o    = pad_sync_i;
                end else begin
                    is_input_o = plain_in;
                    pin_oe     = !plain_in;
                    pin_o      = plain_out;
                    rd_bit_o   = plain_rd;
                    ir_rx_o    = 1'b0;
                end
            end

            // a_r8_rx_forced_input: the IR receive mode never drives the pad.
            always_comb begin
                if (cfg_i.alt && ir_sel_i) begin
                    a_r8_rx_forced_input: assert (!pin_oe && (ir_rx_o == pad_sync_i));
                end
            end
        end else if (ROLE == ROLE_LED_IRTX) begin : g_led
            logic unused_led;
            assign unused_led = wdt_i;

            // LED drive or IR transmit when the alternate is on.
            always_comb begin
                ir_rx_o = 1'b0;
                if (cfg_i.alt) begin
                    is_input_o = 1'b0;
                    pin_oe     = 1'b1;
                    pin_o      = ir_sel_i ? ir_tx_i : led_i;
                    rd_bit_o   = data_i;
                end else begin
                    is_input_o = plain_in;
                    pin_oe     = !plain_in;
                    pin_o      = plain_out;
                    rd_bit_o   = plain_rd;
                end
            end

            // a_r7_led_follows: the LED alternate passes led_i through unchanged.
            always_comb begin
                if (cfg_i.alt && !ir_sel_i) begin
                    a_r7_led_follows: assert (pin_oe && (pin_o == led_i));
                end
            end
        end else begin : g_plain
            logic unused_plain;
            assign unused_plain = ir_sel_i ^ wdt_i ^ led_i ^ ir_tx_i ^ cfg_i.alt;

            // Plain bit: direction and polarity only.
            always_comb begin
                is_input_o = plain_in;
                pin_oe     = !plain_in;
                pin_o      = plain_out;
                rd_bit_o   = plain_rd;
                ir_rx_o    = 1'b0;
            end
        end
    endgenerate
endmodule

// File: rtl/pgpio_regs.sv
// Host register file: per-bit configuration, shared data, global options and
// the registered read path. Assumes single-cycle strobes on a synchronous
// port. A data write is masked by the bits currently acting as inputs.
module pgpio_regs
    import pgpio_pkg::*;
#(
    parameter int NBITS  = 16,
    parameter int ADDR_W = $clog2(NBITS + 2)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic                   rd_en,
    input  logic [ADDR_W-1:0]      addr,
    input  logic [NBITS-1:0]       wr_data,
    input  logic [NBITS-1:0]       in_mask,
    input  logic [NBITS-1:0]       rd_view,
    output bit_cfg_t [NBITS-1:0]   cfg_q,
    output logic [NBITS-1:0]       data_q,
    output logic                   ir_sel_q,
    output logic [NBITS-1:0]       rd_data
);
    localparam int IDX_W = $clog2(NBITS);
    localparam logic [ADDR_W-1:0] DATA_ADDR = ADDR_W'(NBITS);
    localparam logic [ADDR_W-1:0] OPT_ADDR  = ADDR_W'(NBITS + 1);

    logic unused_wr_hi;
    assign unused_wr_hi = ^wr_data[NBITS-1:CFG_W];

    genvar gi;
    generate
        for (gi = 0; gi < NBITS; gi++) begin : g_cfg
            // Store the configuration word of bit gi.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    cfg_q[gi] <= CFG_RESET;
                end else if (wr_en && (addr == ADDR_W'(gi))) begin
                    cfg_q[gi] <= bit_cfg_t'(wr_data[CFG_W-1:0]);
                end
            end

            // R3: an input bit keeps its stored data across a data write.
            a_r3_input_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_en && (addr == DATA_ADDR) && in_mask[gi]) |=> $stable(data_q[gi]));

            // R5: an output bit reads back the stored value.
            a_r5_output_reads_store: assert property (@(posedge clk) disable iff (!rst_n)
                (rd_en && (addr == DATA_ADDR) && !in_mask[gi]) |=> (rd_data[gi] == $past(data_q[gi])));
        end
    endgenerate

    // Update the data register, leaving input bits untouched.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
        end else if (wr_en && (addr == DATA_ADDR)) begin
            data_q <= (data_q & in_mask) | (wr_data & ~in_mask);
        end
    end

    // Store the global IR-select flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ir_sel_q <= 1'b0;
        end else if (wr_en && (addr == OPT_ADDR)) begin
            ir_sel_q <= wr_data[0];
        end
    end

    // Capture the addressed register on a read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (rd_en) begin
            if (addr < DATA_ADDR) begin
                rd_data <= {{(NBITS - CFG_W){1'b0}}, cfg_q[addr[IDX_W-1:0]]};
            end else if (addr == DATA_ADDR) begin
                rd_data <= rd_view;
            end else if (addr == OPT_ADDR) begin
                rd_data <= {{(NBITS - 1){1'b0}}, ir_sel_q};
            end else begin
                rd_data <= '0;
            end
        end
    end

    // R10: a configuration write lands in the addressed entry.
    a_r10_cfg_stored: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (addr < DATA_ADDR)) |=>
        (cfg_q[$past(addr[IDX_W-1:0])] == bit_cfg_t'($past(wr_data[CFG_W-1:0]))));
endmodule

// File: rtl/pgpio_bank.sv
// Top of the GPIO bank. Synchronises the pads, holds the registers and
// instantiates one pad cell per bit, choosing the alternate-function variant
// for WDT_PIN and LED_PIN. Assumes both lie below NBITS and differ.
module pgpio_bank
    import pgpio_pkg::*;
#(
    parameter int NBITS   = 16,
    parameter int WDT_PIN = 12,
    parameter int LED_PIN = 13,
    parameter int ADDR_W  = $clog2(NBITS + 2)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [NBITS-1:0]  host_wdata,
    output logic [NBITS-1:0]  host_rdata,
    input  logic [NBITS-1:0]  pin_i,
    output logic [NBITS-1:0]  pin_o,
    output logic [NBITS-1:0]  pin_oe,
    input  logic              wdt_i,
    input  logic              led_i,
    input  logic              ir_tx_i,
    output logic              ir_rx_o
);
    bit_cfg_t [NBITS-1:0] cfg_q;
    logic [NBITS-1:0]     data_q;
    logic                 ir_sel_q;
    logic [NBITS-1:0]     pad_sync;
    logic [NBITS-1:0]     in_mask;
    logic [NBITS-1:0]     rd_view;
    logic [NBITS-1:0]     rx_vec;

    pgpio_sync #(.W(NBITS)) u_sync (
        .clk (clk),
        .d_i (pin_i),
        .q_o (pad_sync)
    );

    pgpio_regs #(.NBITS(NBITS), .ADDR_W(ADDR_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (host_wr),
        .rd_en    (host_rd),
        .addr     (host_addr),
        .wr_data  (host_wdata),
        .in_mask  (in_mask),
        .rd_view  (rd_view),
        .cfg_q    (cfg_q),
        .data_q   (data_q),
        .ir_sel_q (ir_sel_q),
        .rd_data  (host_rdata)
    );

    genvar gi;
    generate
        for (gi = 0; gi < NBITS; gi++) begin : g_pin
            localparam pin_role_t ROLE = (gi == WDT_PIN) ? ROLE_WDT_IRRX :
                                         (gi == LED_PIN) ? ROLE_LED_IRTX : ROLE_PLAIN;
            pgpio_pin #(.ROLE(ROLE)) u_pin (
                .cfg_i      (cfg_q[gi]),
                .data_i     (data_q[gi]),
                .ir_sel_i   (ir_sel_q),
                .pad_sync_i (pad_sync[gi]),
                .wdt_i      (wdt_i),
                .led_i      (led_i),
                .ir_tx_i    (ir_tx_i),
                .pin_o      (pin_o[gi]),
                .pin_oe     (pin_oe[gi]),
                .is_input_o (in_mask[gi]),
                .rd_bit_o   (rd_view[gi]),
                .ir_rx_o    (rx_vec[gi])
            );
        end
    endgenerate

    // Only the receive-capable cell drives a non-zero rx bit.
    assign ir_rx_o = |rx_vec;

    // R1: the cycle after reset no pad is driven.
    a_r1_reset_no_drive: assert property (@(posedge clk)
        !rst_n |=> (pin_oe == '0));

    // R9: the synchronised level trails the pad by exactly two edges.
    a_r9_two_stage_sync: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_sync == $past(pin_i, 2)));

    // R6: watchdog alternate drives wdt_i with no inversion.
    a_r6_wdt_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q[WDT_PIN].alt && !ir_sel_q) |-> (pin_oe[WDT_PIN] && (pin_o[WDT_PIN] == wdt_i)));
endmodule

// File: tb/pgpio_bank_test.sv
// Directed bench for the GPIO bank: one task per scenario, each checking itself.
module pgpio_bank_test;
    localparam int NBITS  = 16;
    localparam int ADDR_W = 5;
    localparam int WP     = 12;
    localparam int LP     = 13;
    localparam logic [ADDR_W-1:0] DATA_A = ADDR_W'(NBITS);
    localparam logic [ADDR_W-1:0] OPT_A  = ADDR_W'(NBITS + 1);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              host_wr = 1'b0;
    logic              host_rd = 1'b0;
    logic [ADDR_W-1:0] host_addr = '0;
    logic [NBITS-1:0]  host_wdata = '0;
    logic [NBITS-1:0]  host_rdata;
    logic [NBITS-1:0]  pin_i = '0;
    logic [NBITS-1:0]  pin_o;
    logic [NBITS-1:0]  pin_oe;
    logic              wdt_i = 1'b0;
    logic              led_i = 1'b0;
    logic              ir_tx_i = 1'b0;
    logic              ir_rx_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    pgpio_bank #(.NBITS(NBITS), .WDT_PIN(WP), .LED_PIN(LP), .ADDR_W(ADDR_W)) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_wr    (host_wr),
        .host_rd    (host_rd),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .pin_i      (pin_i),
        .pin_o      (pin_o),
        .pin_oe     (pin_oe),
        .wdt_i      (wdt_i),
        .led_i      (led_i),
        .ir_tx_i    (ir_tx_i),
        .ir_rx_o    (ir_rx_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [NBITS-1:0] d);
        @(negedge clk);
        host_wr = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, output logic [NBITS-1:0] d);
        @(negedge clk);
        host_rd = 1'b1; host_addr = a;
        @(negedge clk);
        host_rd = 1'b0;
        d = host_rdata;
    endtask

    task automatic settle();
        repeat (3) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [NBITS-1:0] v;
        check("R1 oe after reset", 32'(pin_oe), 32'h0);
        for (int i = 0; i < NBITS; i += 5) begin
            rd(ADDR_W'(i), v);
            check("R1/R10 cfg reset", 32'(v), 32'h1);
        end
        rd(OPT_A, v);
        check("R1 options reset", 32'(v), 32'h0);
        rd(DATA_A, v);
        check("R1 data reads pads", 32'(v), 32'h A5C3);
    endtask

    task automatic t_input_polarity();
        logic [NBITS-1:0] v;
        pin_i = 16'h3C0F;
        settle();
        rd(DATA_A, v);
        check("R2 plain input read", 32'(v), 32'h3C0F);
        wr(ADDR_W'(4), 16'h0003);
        wr(ADDR_W'(0), 16'h0003);
        rd(ADDR_W'(4), v);
        check("R10 cfg readback", 32'(v), 32'h3);
        rd(DATA_A, v);
        check("R2 inverted input read", 32'(v), 32'h3C1E);
        wr(ADDR_W'(4), 16'h0001);
        wr(ADDR_W'(0), 16'h0001);
    endtask

    task automatic t_sync_latency();
        logic [NBITS-1:0] r1, r2, r3;
        @(negedge clk);
        pin_i = 16'h00F0;
        host_rd = 1'b1; host_addr = DATA_A;
        @(negedge clk); r1 = host_rdata;
        @(negedge clk); r2 = host_rdata;
        @(negedge clk); r3 = host_rdata;
        host_rd = 1'b0;
        check("R9 first read old", 32'(r1), 32'h3C0F);
        check("R9 second read old", 32'(r2), 32'h3C0F);
        check("R9 third read new", 32'(r3), 32'h00F0);
    endtask

    task automatic t_input_write_ignored();
        logic [NBITS-1:0] v;
        wr(DATA_A, 16'hFFFF);
        wr(ADDR_W'(5), 16'h0000);
        check("R3 ignored write pin_o", 32'(pin_o[5]), 32'h0);
        check("R3 pin becomes driven", 32'(pin_oe[5]), 32'h1);
        rd(DATA_A, v);
        check("R3 ignored write readback", 32'(v[5]), 32'h0);
        wr(ADDR_W'(5), 16'h0001);
    endtask

    task automatic t_output_drive();
        logic [NBITS-1:0] v;
        wr(ADDR_W'(2), 16'h0000);
        wr(ADDR_W'(3), 16'h0002);
        wr(DATA_A, 16'h0004);
        check("R4 plain output oe", 32'(pin_oe[3:2]), 32'h3);
        check("R4 plain output level", 32'(pin_o[3:2]), 32'h3);
        pin_i[3:2] = 2'b10;
        settle();
        rd(DATA_A, v);
        check("R5 output reads store", 32'(v[3:2]), 32'h1);
        wr(DATA_A, 16'h0008);
        check("R4 inverted output level", 32'(pin_o[3:2]), 32'h0);
    endtask

    task automatic t_alt_watchdog();
        wr(ADDR_W'(WP), 16'h0005);
        wdt_i = 1'b1;
        @(negedge clk);
        check("R6 wdt drives high", 32'({pin_oe[WP], pin_o[WP]}), 32'h3);
        wdt_i = 1'b0;
        @(negedge clk);
        check("R6 wdt drives low", 32'({pin_oe[WP], pin_o[WP]}), 32'h2);
    endtask

    task automatic t_alt_led();
        wr(ADDR_W'(LP), 16'h0007);
        led_i = 1'b1;
        @(negedge clk);
        check("R7 led no inversion", 32'({pin_oe[LP], pin_o[LP]}), 32'h3);
        led_i = 1'b0;
        @(negedge clk);
        check("R7 led low", 32'(pin_o[LP]), 32'h0);
    endtask

    task automatic t_infrared();
        wr(ADDR_W'(WP), 16'h0004);
        wr(ADDR_W'(LP), 16'h0004);
        wr(OPT_A, 16'h0001);
        check("R8 rx pin forced input", 32'(pin_oe[WP]), 32'h0);
        ir_tx_i = 1'b1;
        @(negedge clk);
        check("R8 tx drives pin", 32'({pin_oe[LP], pin_o[LP]}), 32'h3);
        pin_i[WP] = 1'b1;
        @(negedge clk);
        check("R9 rx one edge old", 32'(ir_rx_o), 32'h0);
        @(negedge clk);
        check("R8/R9 rx two edges new", 32'(ir_rx_o), 32'h1);
        wr(OPT_A, 16'h0000);
        check("R8 rx idle outside IR", 32'(ir_rx_o), 32'h0);
    endtask

    initial begin
        pin_i = 16'hA5C3;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_input_polarity();
        t_sync_latency();
        t_input_write_ignored();
        t_output_drive();
        t_alt_watchdog();
        t_alt_led();
        t_infrared();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule